// File: doc/BRIEF.md
# Display Position Address Scanner

This block walks the visible character positions of a character display during a refresh pass and emits, for each position, the display-RAM address whose code belongs there. It supports a single-line layout of up to 80 positions, and a two-line layout of up to 40 positions per line in which the second line lives at a separate address range starting at 0x40. A scroll offset moves the visible window over the stored text. The window wraps around inside each line's own address range, never across into the other line or the unused gap.

A pulse on `scan_start` captures the layout mode, the visible column count and the current scroll offset. The block then streams one address per position: all columns of line 0 in order, then all columns of line 1 in two-line mode. The output is a valid/ready stream. A beat is transferred on a clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the beat's address, line and column are held unchanged. The producer never withdraws a beat. Scroll strobes and a home command may arrive at any time. They update the stored offset immediately, but the change only appears in the next scan.

Top module: `disp_addr_scanner`

## Requirements
- R1: After reset `out_valid` is 0 and the scroll offset is 0, so an unshifted first scan starts at address 0x00.
- R2: With `two_line` = 0, the beat for column c carries address (c + off) mod 80, and `out_line` = 0.
- R3: With `two_line` = 1, line 0 beats carry (c + off) mod 40 and line 1 beats carry 0x40 + ((c + off) mod 40). Every line 0 beat precedes every line 1 beat.
- R4: A `shift_left` pulse raises the offset by one and a `shift_right` pulse lowers it by one, both modulo the current line length (80 or 40). Both together leave the offset unchanged.
- R5: `home` clears the offset to 0 and takes priority over shift strobes in the same cycle.
- R6: The visible column count is clamped to the line length. A count of 0 produces no beat at all.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_addr`, `out_line` and `out_col` hold their values and `out_valid` stays 1.
- R8: Mode, column count and offset are captured at scan start. Shift strobes, mode changes and `scan_start` pulses during a scan do not alter that scan's beats.
- R9: An offset left at 40 or above by single-line use is taken modulo 40 when two-line mode is in effect, both for address generation and as the base for the next shift.
- R10: Each scan begins with column 0 of line 0, produces exactly one beat per position, and drops `out_valid` after its final transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| two_line | input | 1 | Layout select: 0 single line, 1 two lines |
| vis_cols | input | 7 | Visible columns per line |
| shift_left | input | 1 | Scroll strobe, offset +1 |
| shift_right | input | 1 | Scroll strobe, offset -1 |
| home | input | 1 | Clear the scroll offset |
| scan_start | input | 1 | Begin a scan when idle |
| out_valid | output | 1 | Address beat available |
| out_ready | input | 1 | Consumer accepts the beat |
| out_addr | output | 7 | Display-RAM address for the position |
| out_line | output | 1 | Line index of the beat |
| out_col | output | 7 | Column index of the beat |

## Verification
The hardest cases to reach are the wrap points of the offset in each layout. These are the beat at which a line's addresses fold from the top of its range (0x4F, 0x27 or 0x67) back to its base, and the leftover single-line offset above 39 meeting a two-line scan. The stimulus reaches every wrap point by sweeping the offset one strobe at a time through more than a full turn in both directions, with a scan after each step. It parks the offset at 45 before switching layouts. Scroll strobes, a layout change and a restart pulse are injected in the middle of a scan, with a stalling consumer, to show that the scan in flight is isolated from them.

// File: rtl/disp_scan_pkg.sv
package disp_scan_pkg;
  localparam int unsigned ADDR_W     = 7;
  localparam int unsigned ONE_LEN    = 80;
  localparam int unsigned TWO_LEN    = 40;
  localparam int unsigned LINE2_BASE = 64;

  // line length of the active layout
  function automatic logic [ADDR_W-1:0] line_len(input logic two);
    return two ? ADDR_W'(TWO_LEN) : ADDR_W'(ONE_LEN);
  endfunction
endpackage

// File: rtl/dsa_shift_offset.sv
module dsa_shift_offset
  import disp_scan_pkg::*;
#(
  parameter int unsigned W = ADDR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         two_line,
  input  logic         step_fwd,
  input  logic         step_back,
  input  logic         home,
  output logic [W-1:0] off_eff
);
  logic [W-1:0] off_q;
  logic [W-1:0] len;

  // reduce a stored offset into the active line length
  always_comb begin
    len     = W'(line_len(two_line));
    off_eff = (off_q >= len) ? off_q - len : off_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
    end else if (home) begin
      off_q <= '0;
    end else if (step_fwd && !step_back) begin
      off_q <= (off_eff == len - W'(1)) ? '0 : off_eff + W'(1);
    end else if (step_back && !step_fwd) begin
      off_q <= (off_eff == '0) ? len - W'(1) : off_eff - W'(1);
    end
  end
endmodule

// File: rtl/dsa_scan_seq.sv
module dsa_scan_seq
  import disp_scan_pkg::*;
#(
  parameter int unsigned W = ADDR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         cfg_two,
  input  logic [W-1:0] cfg_cols,
  input  logic [W-1:0] cfg_off,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] col,
  output logic         line,
  output logic         snap_two,
  output logic [W-1:0] snap_off
);
  logic         busy;
  logic [W-1:0] snap_cols;
  logic [W-1:0] len;
  logic [W-1:0] cols_c;
  logic         last_col;

  always_comb begin
    len      = W'(line_len(cfg_two));
    cols_c   = (cfg_cols > len) ? len : cfg_cols;
    last_col = (col == snap_cols - W'(1));
  end

  assign valid = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      col       <= '0;
      line      <= 1'b0;
      snap_two  <= 1'b0;
      snap_off  <= '0;
      snap_cols <= '0;
    end else if (!busy) begin
      if (start && cols_c != '0) begin
        busy      <= 1'b1;
        col       <= '0;
        line      <= 1'b0;
        snap_two  <= cfg_two;
        snap_off  <= cfg_off;
        snap_cols <= cols_c;
      end
    end else if (ready) begin
      if (last_col) begin
        col <= '0;
        if (line || !snap_two) busy <= 1'b0;
        else                   line <= 1'b1;
      end else begin
        col <= col + W'(1);
      end
    end
  end
endmodule

// File: rtl/dsa_addr_map.sv
module dsa_addr_map
  import disp_scan_pkg::*;
#(
  parameter int unsigned W = ADDR_W
) (
  input  logic         two,
  input  logic         line,
  input  logic [W-1:0] col,
  input  logic [W-1:0] off,
  output logic [W-1:0] addr
);
  logic [W:0] sum;
  logic [W:0] len_x;
  logic [W:0] wrapped;

  always_comb begin
    sum     = {1'b0, col} + {1'b0, off};
    len_x   = {1'b0, W'(line_len(two))};
    wrapped = (sum >= len_x) ? sum - len_x : sum;
    addr    = wrapped[W-1:0] + (line ? W'(LINE2_BASE) : '0);
  end
endmodule

// File: rtl/disp_addr_scanner.sv
module disp_addr_scanner
  import disp_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              two_line,
  input  logic [ADDR_W-1:0] vis_cols,
  input  logic              shift_left,
  input  logic              shift_right,
  input  logic              home,
  input  logic              scan_start,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_line,
  output logic [ADDR_W-1:0] out_col
);
  logic [ADDR_W-1:0] off_eff;
  logic [ADDR_W-1:0] snap_off;
  logic              snap_two;

  dsa_shift_offset #(.W(ADDR_W)) u_off (
    .clk(clk), .rst_n(rst_n), .two_line(two_line),
    .step_fwd(shift_left), .step_back(shift_right), .home(home),
    .off_eff(off_eff)
  );

  dsa_scan_seq #(.W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(scan_start),
    .cfg_two(two_line), .cfg_cols(vis_cols), .cfg_off(off_eff),
    .ready(out_ready), .valid(out_valid), .col(out_col), .line(out_line),
    .snap_two(snap_two), .snap_off(snap_off)
  );

  dsa_addr_map #(.W(ADDR_W)) u_map (
    .two(snap_two), .line(out_line), .col(out_col), .off(snap_off),
    .addr(out_addr)
  );
endmodule

// File: rtl/dsa_checker.sv
module dsa_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_ready,
  input logic [6:0] out_addr,
  input logic       out_line,
  input logic [6:0] out_col,
  input logic       snap_two
);
  a_r7_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_line) && $stable(out_col));

  a_r2_single_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !snap_two |-> !out_line && out_addr < 7'd80);

  a_r3_line0_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && snap_two && !out_line |-> out_addr < 7'd40);

  a_r3_line1_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_line |-> out_addr >= 7'd64 && out_addr < 7'd104);

  a_r3_line_order: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_line |=> !out_valid || out_line);

  a_r10_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_col == 7'd0 && !out_line);
endmodule

bind disp_addr_scanner dsa_checker u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_addr(out_addr), .out_line(out_line), .out_col(out_col),
  .snap_two(snap_two)
);

// File: tb/disp_addr_scanner_bench.sv
`timescale 1ns/1ps
module disp_addr_scanner_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       two_line = 1'b0;
  logic [6:0] vis_cols = '0;
  logic       shift_left = 1'b0, shift_right = 1'b0, home = 1'b0;
  logic       scan_start = 1'b0;
  logic       out_ready = 1'b1;
  logic       out_valid, out_line;
  logic [6:0] out_addr, out_col;

  int  vectors = 0;
  int  errs = 0;
  int  ref_off = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  disp_addr_scanner u_disp_addr_scanner (
    .clk(clk), .rst_n(rst_n), .two_line(two_line), .vis_cols(vis_cols),
    .shift_left(shift_left), .shift_right(shift_right), .home(home),
    .scan_start(scan_start), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_line(out_line), .out_col(out_col)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int apply_ref(int off, bit l, bit r, bit h, bit mode);
    int len = mode ? 40 : 80;
    int eff = (off >= len) ? off - len : off;
    if (h) return 0;
    if (l && !r) return (eff + 1) % len;
    if (r && !l) return (eff + len - 1) % len;
    return off;
  endfunction

  task automatic strobe(input bit l, input bit r, input bit h);
    @(negedge clk);
    shift_left = l; shift_right = r; home = h;
    ref_off = apply_ref(ref_off, l, r, h, two_line);
    @(negedge clk);
    shift_left = 0; shift_right = 0; home = 0;
  endtask

  task automatic run_scan(input bit mode, input int cols, input bit stall, input bit mid_evt);
    int len, c, total, eoff, k, cyc;
    @(negedge clk);
    two_line = mode; vis_cols = 7'(cols); scan_start = 1;
    len = mode ? 40 : 80;
    c = (cols > len) ? len : cols;
    total = c * (mode ? 2 : 1);
    eoff = (ref_off >= len) ? ref_off - len : ref_off;
    @(negedge clk);
    scan_start = 0;
    k = 0; cyc = 0;
    while (k < total && cyc < 2000) begin
      shift_left = 0; scan_start = 0; two_line = mode;
      out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
      if (mid_evt && cyc == 3) begin
        // R8: strobe, layout flip and restart pulse while busy
        shift_left = 1; scan_start = 1; two_line = ~mode;
        ref_off = apply_ref(ref_off, 1, 0, 0, ~mode);
      end
      #0.5;
      begin
        int ln = k / c;
        int cl = k % c;
        int ea = (ln ? 64 : 0) + (cl + eoff) % len;
        chk(out_valid === 1'b1, "R10 valid during scan", out_valid, 1);
        chk(out_addr == 7'(ea), mode ? "R3 address" : "R2 address", out_addr, ea);
        chk(out_line == 1'(ln), "R3 line order", out_line, ln);
        chk(out_col == 7'(cl), "R10 column", out_col, cl);
      end
      if (out_ready) k++;
      @(negedge clk);
      cyc++;
    end
    shift_left = 0; scan_start = 0; two_line = mode; out_ready = 1;
    for (int i = 0; i < 3; i++) begin
      #0.5;
      chk(out_valid === 1'b0, "R10/R6 no extra beat", out_valid, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #0.5;
    chk(out_valid === 1'b0, "R1 reset valid", out_valid, 0);
    rst_n = 1;
    // R1: unshifted first scan starts at 0x00
    run_scan(1, 8, 0, 0);
    // R2 / R4: single-line left sweep across the wrap
    for (int s = 0; s < 82; s++) begin
      run_scan(0, 8, s % 2, 0);
      two_line = 0;
      strobe(1, 0, 0);
    end
    strobe(0, 0, 1);
    // R3 / R4: two-line right sweep across the wrap
    for (int s = 0; s < 42; s++) begin
      run_scan(1, 16, s % 2, 0);
      two_line = 1;
      strobe(0, 1, 0);
    end
    // R4: both strobes cancel
    strobe(1, 1, 0);
    run_scan(1, 8, 0, 0);
    // R5: home wins over a shift
    for (int s = 0; s < 5; s++) strobe(1, 0, 0);
    strobe(1, 0, 1);
    run_scan(1, 8, 0, 0);
    // R6: column count sweep with clamping and zero
    two_line = 0;
    for (int s = 0; s < 3; s++) strobe(0, 1, 0);
    for (int c = 0; c < 82; c++) run_scan(0, c, c % 3 == 0, 0);
    for (int c = 0; c < 45; c++) run_scan(1, c, c % 2 == 0, 0);
    // R9: offset parked at 45 in single line, then two-line use
    strobe(0, 0, 1);
    two_line = 0;
    for (int s = 0; s < 45; s++) strobe(1, 0, 0);
    run_scan(1, 40, 0, 0);
    two_line = 1;
    strobe(1, 0, 0);
    run_scan(1, 12, 0, 0);
    run_scan(0, 12, 0, 0);
    // R8: disturbances during a stalled scan, then next scan sees the shift
    run_scan(1, 8, 1, 1);
    run_scan(1, 8, 0, 0);
    run_scan(0, 20, 1, 1);
    run_scan(0, 20, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule